// File: doc/BRIEF.md
# Sliding 3x3 Convolution Window Builder

This block sits in front of a dense-mapped analog multiply array. Feature-map pixels arrive one at a time in raster order over a valid/ready stream. Every pixel carries all of its channels side by side. The block keeps the two previous image rows in line buffers and a short column history. For each output position it emits one flattened window vector. In that vector, each channel's 3x3 patch fills a contiguous group of nine entries, and the channel groups are stacked, so the vector drives all 9*CH array rows in one step.

Pixels outside the image count as zero, with a one-pixel border on every side. At unit stride the window count equals the pixel count. When the half-rate mode is selected, only windows centred on even rows and even columns are produced, which halves both dimensions. The mode is taken at the first pixel of each frame. Windows leave in raster order of their centre, and the final window of a frame is flagged. A stall on the output side holds back the input without losing anything, and each pixel is read from the input exactly once.

Top module: `cwin_row_buffer`

## Requirements
- R1: Entry `ch*9 + dy*3 + dx` of the window vector occupies bits `[idx*DW +: DW]`. It holds channel `ch` of the pixel at row `centre_row + dy - 1`, column `centre_col + dx - 1`, with dy and dx in 0..2 (dy=0 is the upper row, dx=0 the left column). Channel `ch` of an input pixel sits at bits `[ch*DW +: DW]`.
- R2: Every window entry whose pixel lies outside the image (row or column below 0, row at or above IMG_H, column at or above IMG_W) is zero.
- R3: With `half_rate` low, a frame produces IMG_H*IMG_W windows, one per pixel position, in raster order of the centre.
- R4: With `half_rate` high, windows are produced only for centres on even rows and even columns, in raster order: ceil(IMG_H/2)*ceil(IMG_W/2) windows per frame.
- R5: `out_last` is high on the final window of each frame and low on every other window.
- R6: Exactly IMG_H*IMG_W pixels are accepted per frame. `in_ready` is low while the block generates the padding that follows a row or a frame.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_win` and `out_last` stay unchanged on the next cycle, and no input pixel or window is lost.
- R8: After reset, `out_valid` is low and the block expects the first pixel of a new frame.
- R9: Consecutive frames are independent: no pixel of an earlier frame appears in a window of a later frame.
- R10: `half_rate` is sampled when the first pixel of a frame is accepted; changes during the rest of the frame have no effect on that frame's windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_rate | input | 1 | Stride-2 output selection, sampled at a frame's first pixel |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts the input pixel |
| in_pix | input | CH*DW | Input pixel, all channels |
| out_valid | output | 1 | Window vector valid |
| out_ready | input | 1 | Consumer accepts the window |
| out_win | output | 9*CH*DW | Flattened window vector |
| out_last | output | 1 | Final window of the frame |

## Verification
The bench builds the block with three channels, 8-bit samples and a 4-row by 5-column image. This frame is small enough that every window of every frame is checked. The odd width puts the right-edge padding inside a stride-2 window, and the even height leaves one bottom padding row that produces no output at stride 2. Five frames alternate the stride and mix input gaps with output stalls. One frame toggles the mode pin after its first pixel to show that the latched mode governs the frame.

// File: rtl/cwin_pkg.sv
package cwin_pkg;

  localparam int unsigned TAPS = 9;

  // Position of one tap inside the flattened window vector.
  function automatic int unsigned slot_index(input int unsigned ch,
                                             input int unsigned dy,
                                             input int unsigned dx);
    return ch * TAPS + dy * 3 + dx;
  endfunction

  // Whether a centre coordinate produces a window at the chosen stride.
  function automatic logic on_grid(input int unsigned pos, input logic half);
    return half ? ((pos % 2) == 0) : 1'b1;
  endfunction

  // Centre coordinate of the final window along one dimension of n pixels.
  function automatic int unsigned last_center(input int unsigned n, input logic half);
    return half ? ((n - 1) / 2) * 2 : n - 1;
  endfunction

  // Number of windows in one frame.
  function automatic int unsigned windows_per_frame(input int unsigned h,
                                                    input int unsigned w,
                                                    input logic half);
    return half ? ((h + 1) / 2) * ((w + 1) / 2) : h * w;
  endfunction

endpackage

// File: rtl/cwin_scan.sv
module cwin_scan #(
  parameter int unsigned IMG_H = 32,
  parameter int unsigned IMG_W = 32,
  parameter int unsigned RW    = $clog2(IMG_H + 1),
  parameter int unsigned CW    = $clog2(IMG_W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          half_in,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col,
  output logic          half_q,
  output logic          need_px,
  output logic          emit,
  output logic          is_last,
  output logic          above2_pad,
  output logic          above1_pad,
  output logic          right_pad,
  output logic          below_pad
);
  import cwin_pkg::*;

  localparam logic [RW-1:0] ROW_END = RW'(IMG_H);
  localparam logic [CW-1:0] COL_END = CW'(IMG_W);

  logic frame_start;
  assign frame_start = (row == '0) && (col == '0);

  // The sweep covers IMG_H+1 rows by IMG_W+1 columns; the extra row and
  // column are padding steps that consume no input.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row    <= '0;
      col    <= '0;
      half_q <= 1'b0;
    end else if (step) begin
      if (frame_start) half_q <= half_in;
      if (col == COL_END) begin
        col <= '0;
        row <= (row == ROW_END) ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  int unsigned ctr_row, ctr_col;
  always_comb begin
    ctr_row = 32'(row) - 1;
    ctr_col = 32'(col) - 1;
  end

  assign right_pad  = (col == COL_END);
  assign below_pad  = (row == ROW_END);
  assign above1_pad = (row == '0);
  assign above2_pad = (row < RW'(2));
  assign need_px    = !right_pad && !below_pad;
  assign emit       = (row != '0) && (col != '0) &&
                      on_grid(ctr_row, half_q) && on_grid(ctr_col, half_q);
  assign is_last    = emit &&
                      (ctr_row == last_center(IMG_H, half_q)) &&
                      (ctr_col == last_center(IMG_W, half_q));

  // R3
  scan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row <= ROW_END) && (col <= COL_END));

  // R3
  step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !right_pad |=> col == $past(col) + 1'b1);

endmodule

// File: rtl/cwin_lines.sv
module cwin_lines #(
  parameter int unsigned IMG_W = 32,
  parameter int unsigned PW    = 128,
  parameter int unsigned CW    = $clog2(IMG_W + 1)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [CW-1:0] addr,
  input  logic [PW-1:0] wr_pix,
  output logic [PW-1:0] old_pix,
  output logic [PW-1:0] mid_pix
);
  localparam int unsigned AW = (IMG_W > 1) ? $clog2(IMG_W) : 1;

  // old_q holds the row two above the incoming one, mid_q the row just above.
  logic [PW-1:0] old_q [IMG_W];
  logic [PW-1:0] mid_q [IMG_W];

  logic in_range;
  assign in_range = (addr < CW'(IMG_W));

  always_ff @(posedge clk) begin
    if (wr_en) begin
      old_q[addr[AW-1:0]] <= mid_q[addr[AW-1:0]];
      mid_q[addr[AW-1:0]] <= wr_pix;
    end
  end

  assign old_pix = in_range ? old_q[addr[AW-1:0]] : '0;
  assign mid_pix = in_range ? mid_q[addr[AW-1:0]] : '0;

endmodule

// File: rtl/cwin_window.sv
module cwin_window #(
  parameter int unsigned CH = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned PW = CH * DW,
  parameter int unsigned VW = 9 * PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift,
  input  logic [PW-1:0] top_px,
  input  logic [PW-1:0] mid_px,
  input  logic [PW-1:0] bot_px,
  output logic [VW-1:0] win
);
  import cwin_pkg::*;

  // Two retained columns; the third column of the window is the new one.
  logic [PW-1:0] lft_q [3];
  logic [PW-1:0] ctr_q [3];
  logic [PW-1:0] nw    [3];
  logic [PW-1:0] tap   [3][3];

  always_comb begin
    nw[0] = top_px;
    nw[1] = mid_px;
    nw[2] = bot_px;
    for (int dy = 0; dy < 3; dy++) begin
      tap[0][dy] = lft_q[dy];
      tap[1][dy] = ctr_q[dy];
      tap[2][dy] = nw[dy];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int dy = 0; dy < 3; dy++) begin
        lft_q[dy] <= '0;
        ctr_q[dy] <= '0;
      end
    end else if (shift) begin
      for (int dy = 0; dy < 3; dy++) begin
        lft_q[dy] <= ctr_q[dy];
        ctr_q[dy] <= nw[dy];
      end
    end
  end

  for (genvar c = 0; c < CH; c++) begin : g_ch
    for (genvar r = 0; r < 3; r++) begin : g_dy
      for (genvar k = 0; k < 3; k++) begin : g_dx
        localparam int unsigned SLOT = slot_index(c, r, k);
        assign win[SLOT*DW +: DW] = tap[k][r][c*DW +: DW];
      end
    end
  end

endmodule

// File: rtl/cwin_row_buffer.sv
module cwin_row_buffer #(
  parameter int unsigned CH    = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned IMG_H = 32,
  parameter int unsigned IMG_W = 32,
  localparam int unsigned PW   = CH * DW,
  localparam int unsigned VW   = 9 * PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half_rate,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_pix,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VW-1:0] out_win,
  output logic          out_last
);
  import cwin_pkg::*;

  localparam int unsigned RW = $clog2(IMG_H + 1);
  localparam int unsigned CW = $clog2(IMG_W + 1);

  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic half_q, need_px, emit, is_last;
  logic above2_pad, above1_pad, right_pad, below_pad;
  logic slot_free, step;
  logic [PW-1:0] old_pix, mid_pix, top_px, ctr_px, bot_px;
  logic [VW-1:0] win_next;

  assign slot_free = !out_valid || out_ready;
  assign step      = (!need_px || in_valid) && (!emit || slot_free);
  assign in_ready  = need_px && (!emit || slot_free);

  cwin_scan #(.IMG_H(IMG_H), .IMG_W(IMG_W), .RW(RW), .CW(CW)) u_scan (
    .clk(clk), .rst_n(rst_n), .step(step), .half_in(half_rate),
    .row(row), .col(col), .half_q(half_q), .need_px(need_px),
    .emit(emit), .is_last(is_last), .above2_pad(above2_pad),
    .above1_pad(above1_pad), .right_pad(right_pad), .below_pad(below_pad)
  );

  assign bot_px = need_px ? in_pix : '0;

  cwin_lines #(.IMG_W(IMG_W), .PW(PW), .CW(CW)) u_lines (
    .clk(clk), .wr_en(step && !right_pad), .addr(col), .wr_pix(bot_px),
    .old_pix(old_pix), .mid_pix(mid_pix)
  );

  // Rows above the image and the column right of it read as zero; stale
  // line contents from an earlier frame are masked by the row position.
  assign top_px = (above2_pad || right_pad) ? '0 : old_pix;
  assign ctr_px = (above1_pad || right_pad) ? '0 : mid_pix;

  cwin_window #(.CH(CH), .DW(DW), .PW(PW), .VW(VW)) u_win (
    .clk(clk), .rst_n(rst_n), .shift(step),
    .top_px(top_px), .mid_px(ctr_px), .bot_px(bot_px), .win(win_next)
  );

  logic out_half_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_last   <= 1'b0;
      out_win    <= '0;
      out_half_q <= 1'b0;
    end else if (step && emit) begin
      out_valid  <= 1'b1;
      out_last   <= is_last;
      out_win    <= win_next;
      out_half_q <= half_q;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // Windows handed over since the previous frame end.
  int unsigned win_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) win_cnt <= 0;
    else if (out_valid && out_ready) win_cnt <= out_last ? 0 : win_cnt + 1;
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_win) && $stable(out_last));

  // R5
  last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |->
      win_cnt == windows_per_frame(IMG_H, IMG_W, out_half_q) - 1);

  // R6
  no_take_in_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> $past(row) != RW'(IMG_H) && $past(col) != CW'(IMG_W));

endmodule

// File: tb/cwin_row_buffer_test.sv
module cwin_row_buffer_test;
  localparam int CH = 3, DW = 8, H = 4, W = 5;
  localparam int PW = CH * DW, VW = 9 * PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_rate = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [PW-1:0] in_pix = '0;
  logic in_ready, out_valid, out_last;
  logic [VW-1:0] out_win;

  always #4 clk = ~clk;

  cwin_row_buffer #(.CH(CH), .DW(DW), .IMG_H(H), .IMG_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .half_rate(half_rate),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_win(out_win), .out_last(out_last)
  );

  int checks = 0, fails = 0;
  logic [VW-1:0] exp_q[$];
  bit            lst_q[$];
  logic [PW-1:0] pix_q[$];

  function automatic logic [DW-1:0] pv(int f, int r, int c, int ch);
    return DW'(((f * 37 + r * 11 + c * 5 + ch * 29) % 251) + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference: every window of the frame, built from the requirements.
  task automatic build(input int f, input bit half);
    int st;
    st = half ? 2 : 1;
    exp_q.delete(); lst_q.delete(); pix_q.delete();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        logic [PW-1:0] p;
        for (int ch = 0; ch < CH; ch++) p[ch*DW +: DW] = pv(f, r, c, ch);
        pix_q.push_back(p);
      end
    for (int r = 0; r < H; r += st)
      for (int c = 0; c < W; c += st) begin
        logic [VW-1:0] v;
        v = '0;
        for (int ch = 0; ch < CH; ch++)
          for (int dy = 0; dy < 3; dy++)
            for (int dx = 0; dx < 3; dx++) begin
              int rr, cc;
              rr = r + dy - 1; cc = c + dx - 1;
              if (rr >= 0 && rr < H && cc >= 0 && cc < W)
                v[(ch*9 + dy*3 + dx)*DW +: DW] = pv(f, rr, cc, ch);
            end
        exp_q.push_back(v);
        lst_q.push_back(1'b0);
      end
    lst_q[lst_q.size()-1] = 1'b1;
  endtask

  task automatic run_frame(input int f, input bit half, input string tag,
                           input int in_gap, input int out_gap, input bit flip);
    int cyc, got, taken, total;
    bit prev_stall;
    logic [VW-1:0] prev_v;
    build(f, half);
    total = exp_q.size();
    half_rate = half;
    cyc = 0; got = 0; taken = 0; prev_stall = 0; prev_v = '0;
    while (exp_q.size() > 0) begin
      @(negedge clk);
      cyc++;
      if (flip && taken > 0) half_rate = !half;  // R10: change after first pixel
      in_valid  = (pix_q.size() > 0) && (in_gap == 0 || (cyc % in_gap) != 0);
      in_pix    = (pix_q.size() > 0) ? pix_q[0] : '0;
      out_ready = (out_gap == 0 || (cyc % out_gap) != 0);
      #1;
      if (prev_stall)
        chk(out_valid && out_win == prev_v, "R7", "held window", out_win, prev_v);
      prev_stall = out_valid && !out_ready;
      prev_v = out_win;
      if (out_valid && out_ready) begin
        if (got == 0) begin
          // R2: upper-left tap of the first window is padding
          chk(out_win[0 +: DW] == '0, "R2", "corner pad", VW'(out_win[0 +: DW]), '0);
          // R1: channel 1 centre tap is pixel (0,0) channel 1
          chk(out_win[(1*9 + 4)*DW +: DW] == pv(f, 0, 0, 1), "R1", "slot order",
              VW'(out_win[(1*9 + 4)*DW +: DW]), VW'(pv(f, 0, 0, 1)));
        end
        chk(out_win == exp_q[0], tag, "window", out_win, exp_q[0]);
        chk(out_last == lst_q[0], "R5", "last flag", VW'(out_last), VW'(lst_q[0]));
        void'(exp_q.pop_front());
        void'(lst_q.pop_front());
        got++;
      end
      if (in_valid && in_ready) begin
        void'(pix_q.pop_front());
        taken++;
      end
      if (cyc > 5000) begin
        chk(1'b0, tag, "watchdog expired", VW'(got), VW'(total));
        break;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    chk(taken == H * W, "R6", "pixels taken", VW'(taken), VW'(H * W));
    chk(got == total, tag, "window count", VW'(got), VW'(total));
    #1;
    // R6: no further pixel accepted once the frame is complete, during padding
    chk(!(in_ready && pix_q.size() > 0), "R6", "idle ready", VW'(in_ready), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R8", "reset out_valid", VW'(out_valid), '0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R8", "out_valid after reset", VW'(out_valid), '0);
    chk(in_ready == 1'b1, "R8", "ready for first pixel", VW'(in_ready), 1);
    run_frame(0, 1'b0, "R3",  0, 0, 1'b0);
    run_frame(1, 1'b0, "R7",  0, 3, 1'b0);
    run_frame(2, 1'b1, "R4",  2, 0, 1'b0);
    run_frame(3, 1'b1, "R10", 0, 2, 1'b1);
    run_frame(4, 1'b0, "R9",  3, 4, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule